// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects a small set of interrupt request lines (eight by default) and raises one interrupt output to a host processor. It keeps three registers per line: a pending-request register, an in-service register and a mask register. The host programs it through a simple synchronous register-write port. Each write carries a two-bit command selector and one data byte. The host services an interrupt either with a two-pulse acknowledge sequence, which returns a vector byte during the second pulse, or with a poll read.

Priority is circular. A bottom-level pointer names the lowest-priority line, and the line after it in circular order is the highest. Out of reset the pointer sits on the last line, which gives fixed nested priority with line 0 on top. The host can move the pointer directly. Specific and non-specific end-of-interrupt commands can also move it, and so can the automatic end-of-interrupt at the end of an acknowledge sequence. Inputs are edge or level sensitive, and a special mask mode lets masked in-service levels be bypassed.

Top module: `pic_top`

## Requirements
- R1: After reset, `int_out` and `vec_oe` are 0, and the request, in-service and mask registers all read as 0.
- R2: With the bottom pointer at its reset value (last line), line 0 has the highest priority. The second acknowledge pulse returns vector `{base[4:0], level[2:0]}`, where level is the lowest-numbered unmasked pending line and base is config byte bits [7:3]. A config write (selector 0) also restores bottom = last line and clears the in-service, mask and edge-latch state.
- R3: While any in-service bit is set, a request whose priority is equal to or lower than that bit does not raise `int_out`. A request of strictly higher priority does raise it.
- R4: A pending request whose mask bit is set (selector 1 writes the mask byte) raises neither `int_out` nor an in-service bit.
- R5: Priority command (selector 2) bits are R=bit 7, SL=bit 6, EOI=bit 5 and level=bits [2:0]. With EOI=1 and SL=0, the highest-priority set in-service bit is cleared. With EOI=1 and SL=1, the in-service bit of the named level is cleared.
- R6: The priority command with R=1, SL=1, EOI=0 makes the named level the lowest priority. The other levels follow in circular order, so level+1 becomes the highest.
- R7: The priority command with R=1, SL=0, EOI=0 enables rotation on automatic EOI, and R=0, SL=0, EOI=0 disables it. While rotation is enabled, each level serviced with automatic EOI becomes the lowest priority.
- R8: With config bit 1 set, the in-service bit is cleared by itself at the falling edge of the second acknowledge pulse. With the bit clear, the in-service bit stays set until an EOI command clears it.
- R9: Config bit 0 = 0 selects edge mode. A 0-to-1 transition is latched, stays pending after the line drops, and is cleared by the first acknowledge pulse. A line held high does not request again. Config bit 0 = 1 selects level mode, in which the pending bit follows the line.
- R10: Read-control (selector 3) bit 6 = 1 loads special mask mode from bit 5. In special mask mode, every unmasked level that is not in service may interrupt regardless of the in-service bits. A non-specific EOI skips in-service bits whose mask bit is set.
- R11: Read-control bit 2 = 1 arms a poll. The next read returns `{found, 0000, level[2:0]}` with found in bit 7. If a level is found, it moves into service as an acknowledge would. Later reads are status reads again.
- R12: `vec_oe` is 1 only from the rising to the falling edge of the second acknowledge pulse, and `vec_out` is stable while `vec_oe` is 1.
- R13: Read-control bit 1 = 1 loads the status select from bit 0 (0 = request register, 1 = in-service register). A read with `rd_sel` = 0 returns the selected register, and a read with `rd_sel` = 1 returns the mask register, one cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N | Interrupt request lines |
| wr_en | input | 1 | Command write strobe |
| wr_sel | input | 2 | Command selector: 0 config, 1 mask, 2 priority/EOI, 3 read control |
| wr_data | input | 8 | Command byte |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | 0 status/poll, 1 mask |
| rd_data | output | 8 | Registered read result |
| ack | input | 1 | Acknowledge pulse input, active high |
| vec_out | output | 8 | Vector byte |
| vec_oe | output | 1 | Vector valid during the second acknowledge pulse |
| int_out | output | 1 | Interrupt to host |

## Verification
The checks assume that every acknowledge pulse is high for at least one clock and low for at least one clock. They also assume that no command write, poll read or reset falls inside an acknowledge sequence, so that the in-service register gains at most one bit per cycle and only from an unmasked pending line. The stimulus drives one event at a time on the falling clock edge. It separates writes, reads and acknowledge pulses by whole cycles, and it waits out the two-register path from a request line to `int_out` before sampling.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_MASK = 2'd1,
    SEL_PRIO = 2'd2,
    SEL_READ = 2'd3
  } wsel_e;

  // config byte
  localparam int CFG_LEVEL = 0;
  localparam int CFG_AEOI  = 1;
  // priority / EOI byte
  localparam int PC_ROT = 7;
  localparam int PC_SL  = 6;
  localparam int PC_EOI = 5;
  // read-control byte
  localparam int RC_ISR  = 0;
  localparam int RC_UPD  = 1;
  localparam int RC_POLL = 2;
  localparam int RC_SMMV = 5;
  localparam int RC_SMMU = 6;
endpackage

// File: rtl/pic_pick.sv
`timescale 1ns/1ps
// Circular priority picker: scans from bottom+1 upward with wrap.
module pic_pick #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  v,
  input  logic [LW-1:0] bottom,
  output logic          found,
  output logic [LW-1:0] lvl
);
  logic [LW-1:0] idx;
  always_comb begin
    found = 1'b0;
    lvl   = '0;
    idx   = '0;
    for (int k = N-1; k >= 0; k--) begin
      idx = LW'((int'(bottom) + 1 + k) % N);
      if (v[idx]) begin
        found = 1'b1;
        lvl   = idx;
      end
    end
  end
endmodule

// File: rtl/pic_req_cell.sv
`timescale 1ns/1ps
// One request line: edge latch or level follower.
module pic_req_cell (
  input  logic clk,
  input  logic rst,
  input  logic level_mode,
  input  logic clear,
  input  logic take,
  input  logic line,
  output logic req
);
  logic line_q, latch;
  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b0;
      latch  <= 1'b0;
    end else begin
      line_q <= line;
      if (clear) latch <= 1'b0;
      else       latch <= (line & ~line_q) | (latch & ~take);
    end
  end
  assign req = level_mode ? line_q : latch;
endmodule

// File: rtl/pic_top.sv
`timescale 1ns/1ps
module pic_top
  import pic_pkg::*;
#(
  parameter int N  = 8,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  irq_in,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [VW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          rd_sel,
  output logic [VW-1:0] rd_data,
  input  logic          ack,
  output logic [VW-1:0] vec_out,
  output logic          vec_oe,
  output logic          int_out
);
  localparam int LW = $clog2(N);
  localparam int BW = VW - LW;

  function automatic logic [LW-1:0] rank_of(input logic [LW-1:0] l, input logic [LW-1:0] b);
    return LW'((int'(l) + 2*N - int'(b) - 1) % N);
  endfunction

  logic          lvl_trig, aeoi, rot_auto, smm, poll_arm, rd_isr;
  logic [BW-1:0] vbase;
  logic [N-1:0]  imr, isr, irr;
  logic [LW-1:0] bottom, sel_lvl;
  logic          ack_q, ack_ph;

  wsel_e sel;
  assign sel = wsel_e'(wr_sel);
  logic wr_cfg, wr_mask, cmd_prio, wr_read;
  assign wr_cfg   = wr_en && sel == SEL_CFG;
  assign wr_mask  = wr_en && sel == SEL_MASK;
  assign cmd_prio = wr_en && sel == SEL_PRIO;
  assign wr_read  = wr_en && sel == SEL_READ;

  logic [LW-1:0] cmd_lvl;
  assign cmd_lvl = wr_data[LW-1:0];

  // priority pickers
  logic [N-1:0]  req_v, eoi_v;
  logic          req_found, isr_found, eoi_found;
  logic [LW-1:0] req_lvl, isr_lvl, eoi_lvl;
  assign req_v = irr & ~imr & (smm ? ~isr : {N{1'b1}});
  assign eoi_v = smm ? (isr & ~imr) : isr;

  pic_pick #(.N(N), .LW(LW)) u_req (.v(req_v), .bottom(bottom), .found(req_found), .lvl(req_lvl));
  pic_pick #(.N(N), .LW(LW)) u_isr (.v(isr),   .bottom(bottom), .found(isr_found), .lvl(isr_lvl));
  pic_pick #(.N(N), .LW(LW)) u_eoi (.v(eoi_v), .bottom(bottom), .found(eoi_found), .lvl(eoi_lvl));

  logic grant_ok;
  assign grant_ok = req_found &&
                    (smm || !isr_found || rank_of(req_lvl, bottom) < rank_of(isr_lvl, bottom));

  // acknowledge and poll events
  logic ack_rise, ack_fall, take_first, poll_take, auto_eoi;
  assign ack_rise   = ack & ~ack_q;
  assign ack_fall   = ~ack & ack_q;
  assign take_first = ack_rise && !ack_ph;
  assign poll_take  = rd_en && poll_arm;
  assign auto_eoi   = ack_fall && ack_ph && aeoi;

  logic [N-1:0] take_vec, clr_vec;
  assign take_vec = ((take_first || poll_take) && grant_ok) ? (N'(1) << req_lvl) : '0;

  logic ns_cmd, sp_cmd;
  assign ns_cmd = cmd_prio && wr_data[PC_EOI] && !wr_data[PC_SL];
  assign sp_cmd = cmd_prio && wr_data[PC_EOI] &&  wr_data[PC_SL];

  always_comb begin
    clr_vec = '0;
    if ((ns_cmd || auto_eoi) && eoi_found) clr_vec = N'(1) << eoi_lvl;
    else if (sp_cmd)                      clr_vec = N'(1) << cmd_lvl;
  end

  logic          bottom_we;
  logic [LW-1:0] bottom_nx;
  always_comb begin
    bottom_we = 1'b0;
    bottom_nx = bottom;
    if (cmd_prio && wr_data[PC_ROT] && wr_data[PC_SL]) begin
      bottom_we = 1'b1;
      bottom_nx = cmd_lvl;
    end else if (ns_cmd && wr_data[PC_ROT] && eoi_found) begin
      bottom_we = 1'b1;
      bottom_nx = eoi_lvl;
    end else if (auto_eoi && rot_auto && eoi_found) begin
      bottom_we = 1'b1;
      bottom_nx = eoi_lvl;
    end
  end

  logic [VW-1:0] rd_nx;
  always_comb begin
    if (poll_arm)    rd_nx = {grant_ok, {(VW-1-LW){1'b0}}, req_lvl};
    else if (rd_sel) rd_nx = VW'(imr);
    else if (rd_isr) rd_nx = VW'(isr);
    else             rd_nx = VW'(irr);
  end

  // request line cells
  for (genvar g = 0; g < N; g++) begin : g_line
    pic_req_cell u_cell (
      .clk(clk), .rst(rst), .level_mode(lvl_trig), .clear(wr_cfg),
      .take(take_vec[g]), .line(irq_in[g]), .req(irr[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_trig <= 1'b0; aeoi <= 1'b0; rot_auto <= 1'b0; smm <= 1'b0;
      poll_arm <= 1'b0; rd_isr <= 1'b0; vbase <= '0;
      imr <= '0; isr <= '0; bottom <= LW'(N-1); sel_lvl <= '0;
      ack_q <= 1'b0; ack_ph <= 1'b0;
      vec_out <= '0; vec_oe <= 1'b0; int_out <= 1'b0; rd_data <= '0;
    end else begin
      ack_q   <= ack;
      int_out <= grant_ok;
      if (rd_en) rd_data <= rd_nx;
      if (wr_cfg) begin
        lvl_trig <= wr_data[CFG_LEVEL];
        aeoi     <= wr_data[CFG_AEOI];
        vbase    <= wr_data[VW-1:LW];
        imr <= '0; isr <= '0; bottom <= LW'(N-1);
        rot_auto <= 1'b0; smm <= 1'b0; poll_arm <= 1'b0; rd_isr <= 1'b0;
        ack_ph <= 1'b0; vec_oe <= 1'b0;
      end else begin
        isr <= (isr & ~clr_vec) | take_vec;
        if (wr_mask)   imr    <= wr_data[N-1:0];
        if (bottom_we) bottom <= bottom_nx;
        if (cmd_prio && !wr_data[PC_EOI] && !wr_data[PC_SL]) rot_auto <= wr_data[PC_ROT];
        if (wr_read) begin
          poll_arm <= wr_data[RC_POLL];
          if (wr_data[RC_UPD])  rd_isr <= wr_data[RC_ISR];
          if (wr_data[RC_SMMU]) smm    <= wr_data[RC_SMMV];
        end else if (poll_take) begin
          poll_arm <= 1'b0;
        end
        if (take_first) sel_lvl <= grant_ok ? req_lvl : LW'(N-1);
        if (ack_rise && ack_ph) begin
          vec_out <= {vbase, sel_lvl};
          vec_oe  <= 1'b1;
        end
        if (ack_fall) begin
          ack_ph <= ~ack_ph;
          vec_oe <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pic_checks.sv
`timescale 1ns/1ps
module pic_checks #(
  parameter int N  = 8,
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ack,
  input logic          int_out,
  input logic          vec_oe,
  input logic [VW-1:0] vec_out,
  input logic [N-1:0]  isr,
  input logic [N-1:0]  irr,
  input logic [N-1:0]  imr
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!int_out && !vec_oe));

  a_r12_vec_needs_ack: assert property (@(posedge clk) disable iff (rst)
    $rose(vec_oe) |-> $past(ack));

  a_r12_vec_hold: assert property (@(posedge clk) disable iff (rst)
    (vec_oe && $past(vec_oe)) |-> $stable(vec_out));

  a_r3_int_has_cause: assert property (@(posedge clk) disable iff (rst)
    int_out |-> $past(|(irr & ~imr)));

  a_r5_one_new_service: assert property (@(posedge clk) disable iff (rst)
    $countones(isr & ~$past(isr)) <= 1);

  a_r4_masked_not_served: assert property (@(posedge clk) disable iff (rst)
    (isr & ~$past(isr) & $past(imr)) == '0);
endmodule

bind pic_top pic_checks #(.N(N), .VW(VW)) u_checks (
  .clk(clk), .rst(rst), .ack(ack), .int_out(int_out), .vec_oe(vec_oe),
  .vec_out(vec_out), .isr(isr), .irr(irr), .imr(imr)
);

// File: tb/tb_pic_top.sv
`timescale 1ns/1ps
module tb_pic_top;
  localparam int N = 8;
  localparam logic [4:0] BASE = 5'h15;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst = 1'b1;
  logic [N-1:0] irq = '0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = '0;
  logic [7:0]   wr_data = '0;
  logic         rd_en = 1'b0;
  logic         rd_sel = 1'b0;
  logic [7:0]   rd_data;
  logic         ack = 1'b0;
  logic [7:0]   vec_out;
  logic         vec_oe, int_out;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  pic_top #(.N(N)) dut (
    .clk(clk), .rst(rst), .irq_in(irq), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .ack(ack), .vec_out(vec_out), .vec_oe(vec_oe), .int_out(int_out)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; rd_sel = s;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic do_ack(output logic [7:0] v);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    check("R12 first pulse vec_oe", int'(vec_oe), 0);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); v = vec_out;
    check("R12 second pulse vec_oe", int'(vec_oe), 1);
    ack = 1'b0;
    @(negedge clk);
    check("R12 vec_oe after pulse", int'(vec_oe), 0);
  endtask

  function automatic int top_of(input int pat, input int b);
    for (int k = 0; k < N; k++) begin
      int idx = (b + 1 + k) % N;
      if (pat[idx]) return idx;
    end
    return -1;
  endfunction

  function automatic logic [7:0] cfg_byte(input logic lvl, input logic ae);
    return {BASE, 1'b0, ae, lvl};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, v;
    idle(4);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check("R1 int_out", int'(int_out), 0);
    check("R1 vec_oe", int'(vec_oe), 0);
    rd(1'b0, d); check("R1 request reg", int'(d), 0);
    rd(1'b1, d); check("R1 mask reg", int'(d), 0);
    wr(2'd3, 8'h03); rd(1'b0, d); check("R1 in-service reg", int'(d), 0);

    // level mode, no AEOI
    wr(2'd0, cfg_byte(1'b1, 1'b0));

    // R6 R11: poll sweep over every bottom level and request pattern
    for (int b = 0; b < N; b++) begin
      wr(2'd2, 8'hC0 | 8'(b));
      for (int p = 1; p < 256; p++) begin
        irq = 8'(p);
        idle(1);
        wr(2'd3, 8'h04);
        rd(1'b0, d);
        check("R6 R11 poll highest", int'(d), 8'h80 | top_of(p, b));
        wr(2'd2, 8'h20);
        irq = '0;
      end
    end
    wr(2'd2, 8'hC7);
    wr(2'd3, 8'h03); rd(1'b0, d); check("R5 in-service empty after EOIs", int'(d), 0);

    // R2 acknowledge vector sweep with fixed priority
    for (int p = 1; p < 256; p++) begin
      irq = 8'(p);
      idle(3);
      check("R2 int_out on request", int'(int_out), 1);
      do_ack(v);
      check("R2 vector", int'(v), int'({BASE, 3'(top_of(p, N-1))}));
      wr(2'd2, 8'h20);
      irq = '0;
    end
    idle(3);

    // R3 nesting and R5 EOI forms
    irq = 8'h08; idle(3);
    do_ack(v); check("R2 vector level 3", int'(v), int'({BASE, 3'd3}));
    irq = 8'h28; idle(3);
    check("R3 same/lower blocked", int'(int_out), 0);
    irq = 8'h2A; idle(3);
    check("R3 higher passes", int'(int_out), 1);
    do_ack(v); check("R3 nested vector", int'(v), int'({BASE, 3'd1}));
    wr(2'd3, 8'h03); rd(1'b0, d); check("R13 in-service read", int'(d), 8'h0A);
    wr(2'd2, 8'h20); rd(1'b0, d); check("R5 non-specific EOI", int'(d), 8'h08);
    wr(2'd2, 8'h63); rd(1'b0, d); check("R5 specific EOI", int'(d), 8'h00);
    irq = '0; idle(3);

    // R4 mask
    wr(2'd1, 8'h04); irq = 8'h04; idle(3);
    check("R4 masked request", int'(int_out), 0);
    rd(1'b1, d); check("R13 mask read", int'(d), 8'h04);
    wr(2'd1, 8'h00); idle(3);
    check("R4 unmasked request", int'(int_out), 1);
    irq = '0; idle(3);

    // R8 automatic EOI
    wr(2'd0, cfg_byte(1'b1, 1'b1));
    irq = 8'h10; idle(3);
    do_ack(v); check("R8 vector", int'(v), int'({BASE, 3'd4}));
    wr(2'd3, 8'h03); rd(1'b0, d); check("R8 in-service cleared", int'(d), 0);
    irq = '0; idle(3);

    // R7 automatic rotation
    wr(2'd2, 8'h80);
    irq = 8'hFF;
    for (int i = 0; i < 10; i++) begin
      idle(2);
      do_ack(v);
      check("R7 rotation order", int'(v), int'({BASE, 3'(i % N)}));
    end
    wr(2'd2, 8'h00);
    irq = '0; idle(3);

    // R9 edge mode
    wr(2'd0, cfg_byte(1'b0, 1'b0));
    irq = 8'h40; idle(2); irq = '0; idle(3);
    check("R9 edge latched", int'(int_out), 1);
    wr(2'd3, 8'h02); rd(1'b0, d); check("R9 request latched", int'(d), 8'h40);
    do_ack(v); check("R9 edge vector", int'(v), int'({BASE, 3'd6}));
    rd(1'b0, d); check("R9 latch cleared by ack", int'(d), 0);
    wr(2'd2, 8'h20);
    irq = 8'h40; idle(2);
    do_ack(v);
    wr(2'd2, 8'h20); idle(3);
    check("R9 held line no retrigger", int'(int_out), 0);
    rd(1'b0, d); check("R9 held line request", int'(d), 0);
    irq = '0;
    // level mode contrast
    wr(2'd0, cfg_byte(1'b1, 1'b0));
    irq = 8'h40; idle(2);
    rd(1'b0, d); check("R9 level follows high", int'(d), 8'h40);
    irq = '0; idle(2);
    rd(1'b0, d); check("R9 level follows low", int'(d), 0);

    // R10 special mask mode
    irq = 8'h08; idle(3);
    do_ack(v);
    wr(2'd1, 8'h08);
    wr(2'd3, 8'h60);
    irq = 8'h28; idle(3);
    check("R10 lower level passes", int'(int_out), 1);
    do_ack(v); check("R10 vector", int'(v), int'({BASE, 3'd5}));
    wr(2'd3, 8'h03); rd(1'b0, d); check("R10 in-service both", int'(d), 8'h28);
    wr(2'd2, 8'h20); rd(1'b0, d); check("R10 EOI skips masked", int'(d), 8'h08);
    wr(2'd3, 8'h40); wr(2'd1, 8'h00); wr(2'd2, 8'h63);
    irq = '0; idle(3);

    // R11 poll with nothing pending, then back to status reads
    wr(2'd3, 8'h02);
    wr(2'd3, 8'h04); rd(1'b0, d); check("R11 empty poll", int'(d), 0);
    irq = 8'h02; idle(2);
    rd(1'b0, d); check("R11 disarmed after read", int'(d), 8'h02);
    irq = '0; idle(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule